// File: doc/BRIEF.md
# Byte-Lane Host Bridge

This block lets an 8-bit host processor reach a 16-bit internal memory and register bus. The host sees each 16-bit word as two byte locations. The lowest host address bit picks the byte, and the remaining bits give the word address. The host data byte is steered onto either the upper or the lower lane of the 16-bit word.

Only one of the two byte accesses runs a real 16-bit cycle on the internal bus. The other byte is served from, or parked in, a 16-bit holding register. Three strap inputs set the behaviour:

- the polarity of the byte-select bit;
- which byte access triggers the internal cycle;
- whether the host waits on a ready handshake or runs with zero wait states.

Top module: `byte_lane_bridge`

## Requirements
- R1: Byte-select polarity. The accessed byte is the upper byte (bits 15:8) when `h_addr[0]` is 0 and `cfg_sel_pol` is 1, or when `h_addr[0]` is 1 and `cfg_sel_pol` is 0. In all other cases it is the lower byte (bits 7:0).
- R2: Triggering access with `cfg_wait`=1.
  - With `cfg_trig`=1, an upper-byte read and a lower-byte write each start the internal cycle.
  - With `cfg_trig`=0, a lower-byte read and an upper-byte write start it.
- R3: Triggering access with `cfg_wait`=0. With `cfg_trig`=1, lower-byte accesses start the internal cycle for both reads and writes. With `cfg_trig`=0, upper-byte accesses start it.
- R4: A triggering read fetches the whole word and returns the accessed byte on `h_rdata`. The fetched word goes into the holding register, so a later non-triggering read returns its byte lane from that register.
- R5: A non-triggering write stores its byte into the matching lane of the holding register. A triggering write then issues one internal write at its own word address `h_addr[ADDR_W-1:1]`. That write carries the host byte in the accessed lane and the held byte in the other lane.
- R6: Ready handshake with `cfg_wait`=1.
  - `h_ready` stays low from the strobe until the internal cycle is acknowledged.
  - It then stays high while `h_stb` is held.
  - It drops in the clock after `h_stb` is removed.
- R7: With `cfg_wait`=1, a non-triggering access raises `h_ready` in the first clock after the strobe is taken.
- R8: With `cfg_wait`=0, `h_ready` is held high whenever the bridge is out of master clear.
- R9: Internal request rules.
  - `m_req` stays asserted with a stable `m_addr` and `m_we` until `m_ack` is seen, and drops in the next clock.
  - Each triggering access makes exactly one request.
  - A non-triggering access makes none.
- R10: Master clear (`rst_n` low) has four effects:
  - it returns the bridge to idle;
  - it drops a pending `m_req`;
  - it deasserts `h_ready`;
  - it clears the holding register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Master clear, active low |
| cfg_sel_pol | input | 1 | Byte-select polarity strap |
| cfg_trig | input | 1 | Trigger-selection strap |
| cfg_wait | input | 1 | 1 = ready handshake, 0 = zero-wait host cycle |
| h_stb | input | 1 | Host strobe, high for the whole access |
| h_wr | input | 1 | Host direction, 1 = write |
| h_addr | input | ADDR_W | Host address; bit 0 is the byte select |
| h_wdata | input | 8 | Host write byte |
| h_rdata | output | 8 | Host read byte |
| h_ready | output | 1 | Host ready/acknowledge |
| m_req | output | 1 | Internal transfer request |
| m_we | output | 1 | Internal write enable |
| m_addr | output | ADDR_W-1 | Internal word address |
| m_wdata | output | 16 | Internal write word |
| m_rdata | input | 16 | Internal read word |
| m_ack | input | 1 | Internal transfer acknowledge |

## Verification
All eight strap combinations are run. In each one, directed pairs of byte writes and reads go to the same word, followed by seeded random accesses.

The random accesses use random byte lanes, directions and internal acknowledge latencies. A wrong polarity or trigger decode shows up as swapped bytes or as a wrong count of internal requests. A wrong merge shows up in the stored memory word, and a wrong ready timing shows up in the measured handshake cycles.

A master clear issued while a request is stalled separates a correct clear of the request, the ready and the holding register from one that leaves stale state behind.

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge #(
  parameter int ADDR_W = 13,
  localparam int WA_W = ADDR_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_sel_pol,
  input  logic              cfg_trig,
  input  logic              cfg_wait,
  input  logic              h_stb,
  input  logic              h_wr,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [7:0]        h_wdata,
  output logic [7:0]        h_rdata,
  output logic              h_ready,
  output logic              m_req,
  output logic              m_we,
  output logic [WA_W-1:0]   m_addr,
  output logic [15:0]       m_wdata,
  input  logic [15:0]       m_rdata,
  input  logic              m_ack
);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} st_t;

  st_t         st;
  logic [15:0] hold;
  logic        up_q;
  logic        upper;
  logic        fire;

  assign upper = cfg_sel_pol ? ~h_addr[0] : h_addr[0];

  always_comb begin
    if (cfg_wait) fire = h_wr ? (upper != cfg_trig) : (upper == cfg_trig);
    else          fire = (upper != cfg_trig);
  end

  assign h_ready = rst_n & (cfg_wait ? (st == S_DONE) : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      hold    <= '0;
      up_q    <= 1'b0;
      m_req   <= 1'b0;
      m_we    <= 1'b0;
      m_addr  <= '0;
      m_wdata <= '0;
      h_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (h_stb) begin
          up_q <= upper;
          if (fire) begin
            m_req   <= 1'b1;
            m_we    <= h_wr;
            m_addr  <= h_addr[ADDR_W-1:1];
            m_wdata <= upper ? {h_wdata, hold[7:0]} : {hold[15:8], h_wdata};
            st      <= S_BUSY;
          end else begin
            if (h_wr) begin
              if (upper) hold[15:8] <= h_wdata;
              else       hold[7:0]  <= h_wdata;
            end else begin
              h_rdata <= upper ? hold[15:8] : hold[7:0];
            end
            st <= S_DONE;
          end
        end
        S_BUSY: if (m_ack) begin
          m_req <= 1'b0;
          st    <= S_DONE;
          if (!m_we) begin
            hold    <= m_rdata;
            h_rdata <= up_q ? m_rdata[15:8] : m_rdata[7:0];
          end
        end
        S_DONE: if (!h_stb) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/byte_lane_bridge_chk.sv
module byte_lane_bridge_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wait,
  input logic              h_stb,
  input logic              h_ready,
  input logic              m_req,
  input logic              m_we,
  input logic [ADDR_W-2:0] m_addr,
  input logic              m_ack
);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we));

  p_req_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_ack |=> !m_req);

  p_ready_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wait && m_req |-> !h_ready);

  p_ready_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wait && h_ready && !h_stb |=> !h_ready);

  p_zero_wait_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wait |-> h_ready);

  always_comb if (!rst_n) p_clear_ready_r10: assert (!h_ready);

endmodule

bind byte_lane_bridge byte_lane_bridge_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_byte_lane_bridge.sv
`timescale 1ns/1ps
module test_byte_lane_bridge;
  localparam int AW = 13;

  logic clk = 0, rst_n = 0;
  logic cfg_sel_pol = 0, cfg_trig = 0, cfg_wait = 0;
  logic h_stb = 0, h_wr = 0;
  logic [AW-1:0] h_addr = '0;
  logic [7:0] h_wdata = '0, h_rdata;
  logic h_ready, m_req, m_we, m_ack = 0;
  logic [AW-2:0] m_addr;
  logic [15:0] m_wdata, m_rdata = '0;

  byte_lane_bridge #(.ADDR_W(AW)) i_byte_lane_bridge (.*);

  always #2 clk = ~clk;

  int errors = 0, checks = 0, reqs = 0, cycles = 0;
  logic [15:0] mem [16];
  logic [15:0] ref_mem [16];
  logic [15:0] mh;
  logic stall = 0;
  int lat_cnt = 0, lat_goal = 0;

  task automatic check(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit f_upper(input bit pol, input bit a0);
    return pol ? !a0 : a0;
  endfunction

  function automatic bit f_fire(input bit w, input bit t, input bit wr, input bit up);
    if (w) return wr ? (up != t) : (up == t);
    return up != t;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      m_ack = 0; lat_cnt = 0;
    end else if (m_ack) m_ack = 0;
    else if (m_req && !stall) begin
      if (lat_cnt >= lat_goal) begin
        m_ack = 1; reqs++;
        if (m_we) mem[m_addr[3:0]] = m_wdata;
        m_rdata = mem[m_addr[3:0]];
        lat_cnt = 0; lat_goal = $urandom % 4;
      end else lat_cnt++;
    end
  end

  task automatic access(input bit wr, input logic [4:0] a, input logic [7:0] wd);
    bit up, fi;
    logic [3:0] wa;
    logic [7:0] exp;
    int cyc, r0;
    up = f_upper(cfg_sel_pol, a[0]);
    fi = f_fire(cfg_wait, cfg_trig, wr, up);
    wa = a[4:1];
    exp = 0;
    if (wr) begin
      if (fi) ref_mem[wa] = up ? {wd, mh[7:0]} : {mh[15:8], wd};
      else if (up) mh[15:8] = wd; else mh[7:0] = wd;
    end else begin
      if (fi) begin
        exp = up ? ref_mem[wa][15:8] : ref_mem[wa][7:0];
        mh = ref_mem[wa];
      end else exp = up ? mh[15:8] : mh[7:0];
    end
    r0 = reqs;
    @(negedge clk);
    h_stb = 1; h_wr = wr; h_addr = {8'h0, a}; h_wdata = wd;
    cyc = 0;
    if (cfg_wait) begin
      do begin @(negedge clk); cyc++; end while (!h_ready && cyc < 50);
      check(h_ready, "R6 ready raised", h_ready, 1);
      if (!fi) check(cyc == 1, "R7 non-trigger ready latency", cyc, 1);
      else     check(cyc >= 2, "R6 ready held low while busy", cyc, 2);
    end else begin
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if (!h_ready) check(0, "R8 zero-wait ready", h_ready, 1);
      end
    end
    if (!wr) check(h_rdata == exp, fi ? "R4 R2 R3 trigger read byte (R1 lane)"
                                      : "R4 held byte read", h_rdata, exp);
    else if (fi) check(mem[wa] == ref_mem[wa], "R5 merged write word", mem[wa], ref_mem[wa]);
    check(reqs - r0 == int'(fi), "R9 request count", reqs - r0, int'(fi));
    h_stb = 0;
    @(negedge clk);
    if (cfg_wait) check(!h_ready, "R6 ready release", h_ready, 0);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit p, input bit t, input bit w);
    @(negedge clk);
    rst_n = 0; cfg_sel_pol = p; cfg_trig = t; cfg_wait = w;
    @(negedge clk);
    check(!m_req && !h_ready, "R10 reset state", {m_req, h_ready}, 0);
    rst_n = 1; mh = 0;
    @(negedge clk);
    check(h_ready == !w, "R8 R6 ready after reset", h_ready, !w);
  endtask

  initial begin
    void'($urandom(32'h1553));
    for (int i = 0; i < 16; i++) begin
      mem[i] = $urandom; ref_mem[i] = mem[i];
    end
    mh = 0;
    for (int m = 0; m < 8; m++) begin
      do_reset(m[0], m[1], m[2]);
      access(1, 5'h06, 8'hA5); access(1, 5'h07, 8'h3C);
      access(0, 5'h06, 8'h00); access(0, 5'h07, 8'h00);
      access(0, 5'h07, 8'h00); access(0, 5'h06, 8'h00);
      for (int k = 0; k < 40; k++) access($urandom % 2, 5'($urandom), 8'($urandom));
    end
    // R10: master clear during a stalled request
    do_reset(1, 1, 1);
    for (int a0 = 0; a0 < 2; a0++)
      if (!f_fire(1, 1, 1, f_upper(1, a0[0]))) access(1, {4'h2, a0[0]}, 8'h5A);
    stall = 1;
    for (int a0 = 0; a0 < 2; a0++)
      if (f_fire(1, 1, 0, f_upper(1, a0[0]))) begin
        @(negedge clk); h_stb = 1; h_wr = 0; h_addr = {12'h3, a0[0]};
      end
    repeat (3) @(negedge clk);
    check(m_req && !h_ready, "R10 stalled request pending", {m_req, h_ready}, 2);
    rst_n = 0;
    @(negedge clk);
    check(!m_req && !h_ready, "R10 clear drops request and ready", {m_req, h_ready}, 0);
    h_stb = 0; stall = 0;
    @(negedge clk);
    rst_n = 1; mh = 0;
    for (int a0 = 0; a0 < 2; a0++)
      if (!f_fire(1, 1, 0, f_upper(1, a0[0]))) access(0, {4'h2, a0[0]}, 8'h00);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule